// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O peripheral behind a plain memory-mapped register port. The port has an address, a write strobe, write data and read data. Software picks which pins are outputs. It changes output levels with separate write-one-to-set and write-one-to-clear registers, so a single write never disturbs the other pins. It can also read back the synchronised input levels.

Every pin has its own interrupt detector. Three per-pin configuration bits choose the trigger:

- a method bit selects edge or level;
- a both-edges bit selects either-transition detection;
- a polarity bit selects rising or falling in edge mode, and high or low in level mode.

Detected conditions land in a raw status register. Edge conditions latch until software clears them. Level conditions track the pin. An enable register and a mask register filter the raw status, and all surviving bits are ORed into one interrupt line for the whole controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero (all pins are inputs) and `irq_out` is low.
- R2: The direction register at offset 0x00 drives `pin_oe` one cycle after a write; bit n = 1 makes pin n an output. It reads back what was written.
- R3: Writing offset 0x10 sets every output bit whose data bit is 1, and writing offset 0x14 clears every output bit whose data bit is 1. Bits written as 0 keep their value. Reading 0x10 returns the current output latch, which also drives `pin_out`.
- R4: Offset 0x04 returns the pin inputs after a two-flop synchroniser.
- R5: In edge mode (method bit = 0, both-edges bit = 0, polarity bit = 0), a 0-to-1 pin transition sets the pin's raw status bit (offset 0x24) and the bit stays set. A 1-to-0 transition sets nothing.
- R6: In edge mode with polarity bit = 1 and both-edges bit = 0, only a 1-to-0 transition sets the raw status bit.
- R7: In edge mode with both-edges bit = 1, either transition sets the raw status bit.
- R8: In level mode (method bit = 1), the raw status bit equals the synchronised pin when polarity = 0, and its inverse when polarity = 1. It cannot be cleared while the level persists. The method register is at 0x34, both-edges at 0x38 and polarity at 0x3C.
- R9: Writing 1 to bit n of offset 0x30 clears the latched edge status of pin n. Bits written as 0 leave their status untouched.
- R10: Offset 0x28 returns raw AND enable (0x20) AND NOT mask (0x2C). Raw status is reported regardless of enable.
- R11: `irq_out` is high exactly when any bit of the masked status is set.
- R12: Read data appears one cycle after the address is presented. Unmapped offsets read zero, and writes to the read-only offsets 0x04, 0x24 and 0x28 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable (direction) |
| irq_out | output | 1 | Combined interrupt |

## Verification
A corrupted trigger decoder or status latch shows first in the raw status readback, three clock edges after a pin change: two synchroniser stages plus the status flop. It reaches `irq_out` in the same cycle once that pin is enabled. A status bit that leaks away without a clear write, or that a clear fails to remove, is visible at the very next read. A wrong output or direction latch shows on `pin_out`/`pin_oe` one cycle after the offending write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned GPIO_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IN     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SET    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EN     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_METHOD = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_IN,
        SEL_SET,
        SEL_CLR,
        SEL_EN,
        SEL_RAW,
        SEL_MSTAT,
        SEL_MASK,
        SEL_ICLR,
        SEL_METHOD,
        SEL_BOTH,
        SEL_POL
    } regsel_e;

    typedef struct packed {
        logic [GPIO_W-1:0] method;
        logic [GPIO_W-1:0] both;
        logic [GPIO_W-1:0] pol;
    } trig_cfg_t;

    function automatic regsel_e decode_addr(input logic [ADDR_W-1:0] a);
        regsel_e s;
        case (a)
            OFS_DIR:    s = SEL_DIR;
            OFS_IN:     s = SEL_IN;
            OFS_SET:    s = SEL_SET;
            OFS_CLR:    s = SEL_CLR;
            OFS_EN:     s = SEL_EN;
            OFS_RAW:    s = SEL_RAW;
            OFS_MSTAT:  s = SEL_MSTAT;
            OFS_MASK:   s = SEL_MASK;
            OFS_ICLR:   s = SEL_ICLR;
            OFS_METHOD: s = SEL_METHOD;
            OFS_BOTH:   s = SEL_BOTH;
            OFS_POL:    s = SEL_POL;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = gpio_irq_pkg::GPIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= d;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
    input  logic clk,
    input  logic rst,
    input  logic cur,
    input  logic prev,
    input  logic method,
    input  logic both,
    input  logic pol,
    input  logic clr,
    output logic status
);
    logic edge_hit;
    logic level_hit;

    always_comb begin
        level_hit = cur ^ pol;
        if (both) begin
            edge_hit = cur ^ prev;
        end else if (pol) begin
            edge_hit = prev & ~cur;
        end else begin
            edge_hit = cur & ~prev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (method) begin
            status <= level_hit;
        end else begin
            status <= (status & ~clr) | edge_hit;
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = GPIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  regsel_e      sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] mask_q,
    output trig_cfg_t    cfg_q,
    output logic [W-1:0] clr_bits
);
    always_comb begin
        clr_bits = (we && sel == SEL_ICLR) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            en_q   <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (we) begin
            case (sel)
                SEL_DIR:    dir_q      <= wdata;
                SEL_SET:    out_q      <= out_q | wdata;
                SEL_CLR:    out_q      <= out_q & ~wdata;
                SEL_EN:     en_q       <= wdata;
                SEL_MASK:   mask_q     <= wdata;
                SEL_METHOD: cfg_q.method <= wdata;
                SEL_BOTH:   cfg_q.both <= wdata;
                SEL_POL:    cfg_q.pol  <= wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic              irq_out
);
    localparam int unsigned W = GPIO_W;

    regsel_e      sel;
    logic [W-1:0] dir_q, out_q, en_q, mask_q, clr_bits;
    trig_cfg_t    cfg_q;
    logic [W-1:0] sync_cur, sync_prev;
    logic [W-1:0] raw_q;
    logic [W-1:0] masked;
    logic [W-1:0] method_bits;
    logic [W-1:0] rdata_q;

    always_comb sel = decode_addr(bus_addr);

    gpio_regfile #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .sel(sel), .we(bus_we), .wdata(bus_wdata),
        .dir_q(dir_q), .out_q(out_q), .en_q(en_q), .mask_q(mask_q),
        .cfg_q(cfg_q), .clr_bits(clr_bits)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .cur(sync_cur), .prev(sync_prev)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_detect u_det (
            .clk(clk), .rst(rst),
            .cur(sync_cur[i]), .prev(sync_prev[i]),
            .method(cfg_q.method[i]), .both(cfg_q.both[i]), .pol(cfg_q.pol[i]),
            .clr(clr_bits[i]), .status(raw_q[i])
        );
    end

    always_comb begin
        masked      = raw_q & en_q & ~mask_q;
        method_bits = cfg_q.method;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            case (sel)
                SEL_DIR:    rdata_q <= dir_q;
                SEL_IN:     rdata_q <= sync_cur;
                SEL_SET:    rdata_q <= out_q;
                SEL_EN:     rdata_q <= en_q;
                SEL_RAW:    rdata_q <= raw_q;
                SEL_MSTAT:  rdata_q <= masked;
                SEL_MASK:   rdata_q <= mask_q;
                SEL_METHOD: rdata_q <= cfg_q.method;
                SEL_BOTH:   rdata_q <= cfg_q.both;
                SEL_POL:    rdata_q <= cfg_q.pol;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;
    assign irq_out   = |masked;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [GPIO_W-1:0] bus_wdata,
    input logic [GPIO_W-1:0] bus_rdata,
    input logic [GPIO_W-1:0] pin_out,
    input logic [GPIO_W-1:0] pin_oe,
    input logic              irq_out,
    input logic [GPIO_W-1:0] raw,
    input logic [GPIO_W-1:0] en,
    input logic [GPIO_W-1:0] method
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq_out && raw == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata));

    assert_set_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    assert_clr_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    assert_edge_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ((($past(raw) & ~$past(method)) & ~raw) == '0));

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((raw & en) != '0));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (decode_addr(bus_addr) == SEL_NONE) |=> bus_rdata == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out), .raw(raw_q), .en(en_q),
    .method(method_bits)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // monitor: compares read data when each scoreboard item falls due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        it.exp = exp;
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 8'hFC;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(pin_oe, 32'h0, "R1 pin_oe");
        chk(pin_out, 32'h0, "R1 pin_out");
        chk({31'h0, irq_out}, 32'h0, "R1 irq_out");
        rd(8'h00, 32'h0, "R1 dir");
        rd(8'h24, 32'h0, "R1 raw");
        rd(8'h34, 32'h0, "R1 method");
        rd(8'h20, 32'h0, "R1 enable");

        // R2 direction
        wr(8'h00, 32'h0000FFFF);
        chk(pin_oe, 32'h0000FFFF, "R2 pin_oe");
        rd(8'h00, 32'h0000FFFF, "R2 readback");

        // R3 set / clear
        wr(8'h10, 32'h000000A5);
        chk(pin_out, 32'h000000A5, "R3 set");
        wr(8'h10, 32'h00000100);
        rd(8'h10, 32'h000001A5, "R3 set keeps others");
        wr(8'h14, 32'h00000005);
        chk(pin_out, 32'h000001A0, "R3 clear");
        rd(8'h10, 32'h000001A0, "R3 readback");

        // R4 synchronised input
        @(negedge clk) pin_in = 32'h12345678;
        idle(4);
        rd(8'h04, 32'h12345678, "R4 input");
        @(negedge clk) pin_in = 32'h0;
        idle(4);

        // trigger config: p0 rise, p1 fall, p2 both, p3 level high, p4 level low
        wr(8'h34, 32'h00000018);
        wr(8'h38, 32'h00000004);
        wr(8'h3C, 32'h00000012);
        rd(8'h3C, 32'h00000012, "R8 polarity readback");
        wr(8'h30, 32'hFFFFFFFF);
        idle(2);
        rd(8'h24, 32'h00000010, "R8 level low active, R9 edges cleared");

        @(negedge clk) pin_in = 32'h0000001F;
        idle(4);
        rd(8'h24, 32'h0000000D, "R5 R7 R8 rising pattern");
        wr(8'h30, 32'hFFFFFFFF);
        idle(2);
        rd(8'h24, 32'h00000008, "R8 level persists R9 clear");

        @(negedge clk) pin_in = 32'h0;
        idle(4);
        rd(8'h24, 32'h00000016, "R6 R7 R8 falling pattern");
        wr(8'h30, 32'h00000002);
        idle(1);
        rd(8'h24, 32'h00000014, "R9 partial clear");

        // R10 / R11 masking
        rd(8'h28, 32'h0, "R10 masked with no enable");
        chk({31'h0, irq_out}, 32'h0, "R11 irq low without enable");
        wr(8'h20, 32'h00000004);
        chk({31'h0, irq_out}, 32'h1, "R11 irq on enable");
        rd(8'h28, 32'h00000004, "R10 masked enable");
        wr(8'h2C, 32'h00000004);
        chk({31'h0, irq_out}, 32'h0, "R11 irq masked off");
        rd(8'h28, 32'h0, "R10 mask hides");
        wr(8'h2C, 32'h0);
        wr(8'h20, 32'h00000010);
        chk({31'h0, irq_out}, 32'h1, "R11 irq level pin");
        rd(8'h28, 32'h00000010, "R10 masked level");
        rd(8'h24, 32'h00000014, "R10 raw ignores enable");

        // R12 read-only and unmapped
        wr(8'h24, 32'hFFFFFFFF);
        wr(8'h28, 32'h0);
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h24, 32'h00000014, "R12 raw write ignored");
        rd(8'h04, 32'h0, "R12 input write ignored");
        rd(8'h08, 32'h0, "R12 unmapped");
        rd(8'h10, 32'h000001A0, "R12 output unchanged");
        drain();
        idle(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule